// File: doc/BRIEF.md
# Wiper Setting Register with Linear and Logarithmic Stepping

This block keeps the code that selects the tap of a digitally controlled resistor divider and carries out every change that may be applied to it. A command strobe with an operation code either writes a supplied code, copies in the value restored from nonvolatile storage, moves the code by one step up or down, or doubles or halves it. Doubling or halving the code moves the divider level by roughly 6 dB per command. A separate preset request also copies in the stored value.

The register value drives the output at all times, so a serial readback path can sample it directly. Serial framing, storage timing and the resistor network live outside the block.

Top module: `wiper_adjust`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wiper` holds mid-scale, code 512.
- R2: A strobe with opcode 3'd1 (load) writes `load_val` into `wiper` at the next clock edge.
- R3: A strobe with opcode 3'd2 (restore) writes `restore_val` into `wiper` at the next clock edge.
- R4: `preset` high copies `restore_val` into `wiper` at the next clock edge and overrides any command strobe in that cycle.
- R5: Opcode 3'd3 (step up) adds one to the code. At code 1023 the code stays 1023 and does not wrap.
- R6: Opcode 3'd4 (step down) subtracts one from the code. At code 0 the code stays 0 and does not wrap.
- R7: Opcode 3'd5 (shift up) doubles the code. Code 0 becomes 1, and any code of 512 or above becomes 1023.
- R8: Opcode 3'd6 (shift down) halves the code and drops the lowest bit, so 1 becomes 0 and 0 stays 0.
- R9: With no strobe and no preset, or with a strobe that carries opcode 3'd0 or 3'd7, `wiper` keeps its value.
- R10: Each result is visible on `wiper` one clock after its command, so a chain of commands applies in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset to mid-scale |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation code (encodings in R2 to R9) |
| load_val | input | 10 | Code for the direct load command |
| restore_val | input | 10 | Code restored from nonvolatile storage |
| preset | input | 1 | Restore request, overrides a command |
| wiper | output | 10 | Present wiper code, used for readback |

## Verification
The bound checker checks the following on every cycle: step up and step down with their saturation, shifting up from zero and from the upper half, direct load, restore, preset priority, and holding while idle. The mid-scale value after reset and correct ordering over long back-to-back command chains can only be shown by the bench scenarios. The bench runs those chains against its own model, mixing random opcodes with walks to both ends of the range.

// File: rtl/wiper_adjust.sv
module wiper_adjust #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] restore_val,
  input  logic         preset,
  output logic [W-1:0] wiper
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] MIDV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  localparam logic [2:0] OP_LOAD = 3'd1;
  localparam logic [2:0] OP_REST = 3'd2;
  localparam logic [2:0] OP_INC  = 3'd3;
  localparam logic [2:0] OP_DEC  = 3'd4;
  localparam logic [2:0] OP_SHL  = 3'd5;
  localparam logic [2:0] OP_SHR  = 3'd6;

  logic [W-1:0] code_q, code_d;
  logic [W-1:0] inc_v, dec_v, shl_v, shr_v;
  logic         at_top, at_bot;

  assign at_top = (code_q == MAXV);
  assign at_bot = (code_q == '0);

  assign inc_v = at_top ? code_q : code_q + ONE;
  assign dec_v = at_bot ? code_q : code_q - ONE;
  assign shl_v = at_bot ? ONE : (code_q[W-1] ? MAXV : {code_q[W-2:0], 1'b0});
  assign shr_v = {1'b0, code_q[W-1:1]};

  always_comb begin
    code_d = code_q;
    if (preset) begin
      code_d = restore_val;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_LOAD: code_d = load_val;
        OP_REST: code_d = restore_val;
        OP_INC:  code_d = inc_v;
        OP_DEC:  code_d = dec_v;
        OP_SHL:  code_d = shl_v;
        OP_SHR:  code_d = shr_v;
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= MIDV;
    else        code_q <= code_d;
  end

  assign wiper = code_q;
endmodule

// File: rtl/wiper_adjust_chk.sv
module wiper_adjust_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] load_val,
  input logic [W-1:0] restore_val,
  input logic         preset,
  input logic [W-1:0] wiper
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic cmd;
  assign cmd = cmd_valid && !preset;

  assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> wiper == $past(restore_val));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd1 |=> wiper == $past(load_val));
  assert_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd2 |=> wiper == $past(restore_val));
  assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd3 && wiper != MAXV |=> wiper == $past(wiper) + ONE);
  assert_inc_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd3 && wiper == MAXV |=> wiper == MAXV);
  assert_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd4 && wiper != '0 |=> wiper == $past(wiper) - ONE);
  assert_dec_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd4 && wiper == '0 |=> wiper == '0);
  assert_shl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd5 && wiper == '0 |=> wiper == ONE);
  assert_shl_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd5 && wiper[W-1] |=> wiper == MAXV);
  assert_shr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && cmd_op == 3'd6 |=> wiper[W-1] == 1'b0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !preset && (!cmd_valid || cmd_op == 3'd0 || cmd_op == 3'd7) |=> $stable(wiper));
endmodule

bind wiper_adjust wiper_adjust_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .load_val(load_val), .restore_val(restore_val), .preset(preset), .wiper(wiper)
);

// File: tb/wiper_adjust_tb.sv
module wiper_adjust_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [9:0] load_val = 10'd0;
  logic [9:0] restore_val = 10'd0;
  logic       preset = 1'b0;
  logic [9:0] wiper;

  int checks = 0;
  int failures = 0;
  int exp_w = 512;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wiper_adjust dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .load_val(load_val), .restore_val(restore_val), .preset(preset), .wiper(wiper)
  );

  function automatic int model(int cur, bit v, int op, int ld, int rs, bit pr);
    if (pr) return rs;
    if (!v) return cur;
    case (op)
      1: return ld;
      2: return rs;
      3: return (cur == 1023) ? cur : cur + 1;
      4: return (cur == 0) ? cur : cur - 1;
      5: return (cur == 0) ? 1 : ((cur * 2 > 1023) ? 1023 : cur * 2);
      6: return cur / 2;
      default: return cur;
    endcase
  endfunction

  function automatic string tag(bit v, int op, bit pr);
    if (pr) return "R4";
    if (!v) return "R9";
    case (op)
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, int exp);
    checks++;
    if (int'(wiper) != exp) begin
      failures++;
      $display("FAIL %s wiper=%0d expected=%0d", req, wiper, exp);
    end
  endtask

  task automatic step(bit v, int op, int ld, int rs, bit pr);
    @(negedge clk);
    cmd_valid = v; cmd_op = op[2:0]; load_val = ld[9:0];
    restore_val = rs[9:0]; preset = pr;
    exp_w = model(exp_w, v, op, ld, rs, pr);
    @(negedge clk);
    check(tag(v, op, pr), exp_w);
    cmd_valid = 1'b0; preset = 1'b0;
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog wiper=%0d expected=done", wiper);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", 512);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 512);
    exp_w = 512;

    step(1, 3, 0, 0, 0);
    step(1, 1, 1022, 0, 0);
    step(1, 3, 0, 0, 0);
    step(1, 3, 0, 0, 0);
    step(1, 5, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(1, 4, 0, 0, 0);
    step(1, 5, 0, 0, 0);
    step(1, 5, 0, 0, 0);
    step(1, 1, 512, 0, 0);
    step(1, 5, 0, 0, 0);
    step(1, 1, 511, 0, 0);
    step(1, 5, 0, 0, 0);
    step(1, 6, 0, 0, 0);
    step(1, 1, 1, 0, 0);
    step(1, 6, 0, 0, 0);
    step(1, 6, 0, 0, 0);
    step(1, 2, 0, 777, 0);
    step(1, 3, 0, 100, 1);
    step(0, 0, 0, 0, 0);
    step(1, 0, 55, 66, 0);
    step(1, 7, 55, 66, 0);
    step(1, 1, 300, 0, 0);
    step(1, 3, 0, 0, 0);

    // R10: back-to-back commands, one per cycle, checked each cycle
    for (int i = 0; i < 3000; i++) begin
      bit v, pr;
      int op, ld, rs;
      v  = ($urandom % 8) != 0;
      pr = ($urandom % 20) == 0;
      op = $urandom % 8;
      ld = $urandom % 1024;
      rs = $urandom % 1024;
      @(negedge clk);
      cmd_valid = v; cmd_op = op[2:0]; load_val = ld[9:0];
      restore_val = rs[9:0]; preset = pr;
      @(posedge clk);
      exp_w = model(exp_w, v, op, ld, rs, pr);
      #1;
      check("R10", exp_w);
    end
    @(negedge clk);
    cmd_valid = 1'b0; preset = 1'b0;

    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 512);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule